// File: doc/BRIEF.md
# Lock-Protected System Control Register File

This block is the system control register file of a processor module. A host reaches it over a word-addressed register bus with a select strobe, a write enable, a byte address and 32-bit write and read data. Reads are registered: the read data for an access appears in the cycle after the select, and it holds its value until the next read. The block returns fixed identification and status words and holds a main and an auxiliary oscillator setting. Both settings are protected by a 16-bit unlock key held in a lock register.

Two flag words are changed only through dedicated set and clear addresses, so software never needs a read-modify-write. The SDRAM configuration word resets with a size code taken from a memory-size parameter. A read-only byte window presents serial-presence-detect style entries from a small computed table. A control register drives a registered LED level and a registered remap level, and its bit 3 raises a one-cycle reset request. An access to an index the block does not decode raises a one-cycle error pulse.

Top module: `sysctl_regs`

## Requirements
- R1: While `rst_n` is low and after its release, `bus_rdata` is 0, `remap_active` is 1, and `led_on`, `reset_req` and `bad_access` are 0.
- R2: Register index is byte address bits [ADDR_W-1:2]. Index 0 reads 0x411A3001, index 4 reads 0x00100000, and index 1 reads 0. Writes to these indices change nothing.
- R3: A write to index 5 stores only data bits [15:0] in the lock register. A read of index 5 returns 0x0001A05F while the stored value is 0xA05F, and otherwise returns the stored 16 bits zero-extended.
- R4: The main oscillator word (index 2, reset 0x01000048) and the auxiliary oscillator word (index 7, reset 0x0007FEFF) accept a write only while the lock register holds 0xA05F. At any other time the write is dropped.
- R5: Index 12 reads the flag word. A write to index 12 ORs the data into it, and a write to index 13 clears each bit that is set in the data. Indices 14 and 15 do the same for a second flag word that is read at index 14. Both words reset to 0, and reads of 13 and 15 return 0.
- R6: Indices 64 to 95 return table entry (index − 64) in bits [7:0]. Entry 0 is 0x80, 1 is 0x08, 2 is 0x04, 3 is 0x0B, 4 is 0x09, 5 is 0x01, 6 is 0x40, and entry 31 is a density byte of 64, 32, 16, 4 or 2 for a memory of at least 256, 128, 64 or 32 MB, or less. Every other entry, and every read of indices 96 to 127, returns 0.
- R7: The SDRAM word (index 8) resets to 0x00011122 ORed with a size code. The code is 0x10 for at least 256 MB, 0x0C for at least 128 MB, 0x08 for at least 64 MB, 0x04 for at least 32 MB, and 0 below that.
- R8: The SDRAM word and the init word (index 9, reset 0x00000112) take any 32-bit write and read back what was written.
- R9: A write to index 3 with data bit 3 set makes `reset_req` high for exactly the following cycle.
- R10: A write to index 3 loads data bit 0 into `led_on` and data bit 2 into the remap select. `remap_active` is the inverse of that select. Both outputs change in the cycle after the write, and index 3 reads back the select in bit 2 and the LED in bit 0.
- R11: An access to any other index reads 0 and leaves every register unchanged, and `bad_access` is high for the following cycle.
- R12: `bus_rdata` changes only in the cycle after a read access, and a write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| remap_active | output | 1 | Low-memory remap level |
| led_on | output | 1 | LED level |
| reset_req | output | 1 | One-cycle board reset request |
| bad_access | output | 1 | One-cycle pulse for an undecoded index |

## Verification
On every cycle, the assertions check the following. An oscillator word changes only after an unlocked write to it. Set and clear writes leave the flag word with the named bits set or cleared. A reset request or an error pulse is always preceded by the access that causes it. The LED and remap levels move only after a control write, and the read data holds when there was no read. Only the bench scenarios can show the rest: the actual values read back, the lock readback flag, the effect of the upper key half, the table contents and the zero upper window, the parameter-chosen SDRAM code, and that a rejected write leaves every register as it was. The bench uses seeded random traffic against a register model, together with directed sequences.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int unsigned DW = 32;

    localparam logic [DW-1:0] ID_WORD    = 32'h411A_3001;
    localparam logic [DW-1:0] STAT_WORD  = 32'h0010_0000;
    localparam logic [DW-1:0] OSC_RST    = 32'h0100_0048;
    localparam logic [DW-1:0] AUX_RST    = 32'h0007_FEFF;
    localparam logic [DW-1:0] INIT_RST   = 32'h0000_0112;
    localparam logic [DW-1:0] SDRAM_BASE = 32'h0001_1122;
    localparam logic [15:0]   UNLOCK_KEY = 16'hA05F;

    // word indices (byte offset >> 2)
    localparam int unsigned IX_ID     = 0;
    localparam int unsigned IX_PROC   = 1;
    localparam int unsigned IX_OSC    = 2;
    localparam int unsigned IX_CTRL   = 3;
    localparam int unsigned IX_STAT   = 4;
    localparam int unsigned IX_LOCK   = 5;
    localparam int unsigned IX_AUX    = 7;
    localparam int unsigned IX_SDRAM  = 8;
    localparam int unsigned IX_INIT   = 9;
    localparam int unsigned IX_FLG    = 12;
    localparam int unsigned IX_FLGC   = 13;
    localparam int unsigned IX_NVF    = 14;
    localparam int unsigned IX_NVFC   = 15;
    localparam int unsigned IX_PD_LO  = 64;
    localparam int unsigned PD_ENTRIES = 32;

    localparam int unsigned NUM_BANKS = 2;

    // SDRAM size code chosen by memory size in MB
    function automatic logic [7:0] size_code(int unsigned mb);
        if (mb >= 256)      return 8'h10;
        else if (mb >= 128) return 8'h0C;
        else if (mb >= 64)  return 8'h08;
        else if (mb >= 32)  return 8'h04;
        else                return 8'h00;
    endfunction

    // density byte of the presence-detect table
    function automatic logic [7:0] density_byte(int unsigned mb);
        if (mb >= 256)      return 8'd64;
        else if (mb >= 128) return 8'd32;
        else if (mb >= 64)  return 8'd16;
        else if (mb >= 32)  return 8'd4;
        else                return 8'd2;
    endfunction

    typedef struct packed {
        logic [DW-1:0] rdata;
        logic [DW-1:0] sdram;
        logic [DW-1:0] init;
        logic          led;
        logic          map_sel;
        logic          rst_req;
        logic          err;
    } top_state_t;

endpackage

// File: rtl/sysctl_key_gate.sv
module sysctl_key_gate
    import sysctl_pkg::*;
#(
    parameter logic [DW-1:0] OSC_INIT = OSC_RST,
    parameter logic [DW-1:0] AUX_INIT = AUX_RST
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lock_we,
    input  logic          osc_we,
    input  logic          aux_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] lock_rd,
    output logic [DW-1:0] osc_q,
    output logic [DW-1:0] aux_q,
    output logic          unlocked
);

    logic [15:0]   lock_q, lock_d;
    logic [DW-1:0] osc_d, aux_d;

    assign unlocked = (lock_q == UNLOCK_KEY);

    always_comb begin
        lock_d  = lock_we ? wdata[15:0] : lock_q;
        osc_d   = (osc_we && unlocked) ? wdata : osc_q;
        aux_d   = (aux_we && unlocked) ? wdata : aux_q;
        lock_rd = {{(DW-17){1'b0}}, unlocked, lock_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= '0;
            osc_q  <= OSC_INIT;
            aux_q  <= AUX_INIT;
        end else begin
            lock_q <= lock_d;
            osc_q  <= osc_d;
            aux_q  <= aux_d;
        end
    end

    // R4: a protected word moves only after an accepted write
    p_osc_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_q != $past(osc_q)) |-> $past(osc_we && unlocked));
    p_aux_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_q != $past(aux_q)) |-> $past(aux_we && unlocked));

endmodule

// File: rtl/sysctl_flag_bank.sv
module sysctl_flag_bank
    import sysctl_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] val_q
);

    logic [W-1:0] val_d;

    always_comb begin
        val_d = val_q;
        if (set_en)      val_d = val_q | wdata;
        else if (clr_en) val_d = val_q & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    // R5: set writes leave named bits set, clear writes leave them cleared
    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((val_q & $past(wdata)) == $past(wdata)));
    p_flag_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> ((val_q & $past(wdata)) == '0));

endmodule

// File: rtl/sysctl_pd_rom.sv
module sysctl_pd_rom
    import sysctl_pkg::*;
#(
    parameter int unsigned MEM_MB  = 128,
    parameter int unsigned ENTRIES = PD_ENTRIES,
    localparam int unsigned EW     = $clog2(ENTRIES)
) (
    input  logic [EW-1:0] entry,
    output logic [7:0]    byte_o
);

    localparam logic [7:0] DENS = density_byte(MEM_MB);

    always_comb begin
        case (32'(entry))
            0:           byte_o = 8'h80;
            1:           byte_o = 8'h08;
            2:           byte_o = 8'h04;
            3:           byte_o = 8'h0B;
            4:           byte_o = 8'h09;
            5:           byte_o = 8'h01;
            6:           byte_o = 8'h40;
            ENTRIES - 1: byte_o = DENS;
            default:     byte_o = 8'h00;
        endcase
    end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned MEM_MB = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              remap_active,
    output logic              led_on,
    output logic              reset_req,
    output logic              bad_access
);

    localparam int unsigned IDX_W = ADDR_W - 2;
    localparam int unsigned PD_AW = $clog2(PD_ENTRIES);
    localparam logic [DW-1:0] SDRAM_RST = SDRAM_BASE | {24'h0, size_code(MEM_MB)};
    localparam top_state_t RESET_STATE = '{
        rdata: '0, sdram: SDRAM_RST, init: INIT_RST,
        led: 1'b0, map_sel: 1'b0, rst_req: 1'b0, err: 1'b0};

    top_state_t state_q, state_d;

    logic [IDX_W-1:0] idx;
    logic             rd_acc, wr_acc;
    logic             pd_window, pd_upper;
    logic [7:0]       pd_byte;
    logic             known;
    logic [DW-1:0]    rval;
    logic [DW-1:0]    lock_rd, osc_val, aux_val;
    logic             unlocked;
    logic             wr_lock, wr_osc, wr_aux;
    logic [NUM_BANKS-1:0] flg_set, flg_clr;
    logic [DW-1:0]    flag_val [NUM_BANKS];
    logic             unused_lsb;

    assign unused_lsb = ^bus_addr[1:0];
    assign idx        = bus_addr[ADDR_W-1:2];
    assign rd_acc     = bus_sel && !bus_we;
    assign wr_acc     = bus_sel && bus_we;
    assign pd_window  = (32'(idx) >= IX_PD_LO) && (32'(idx) < IX_PD_LO + 2 * PD_ENTRIES);
    assign pd_upper   = 32'(idx) >= IX_PD_LO + PD_ENTRIES;

    assign wr_lock    = wr_acc && (32'(idx) == IX_LOCK);
    assign wr_osc     = wr_acc && (32'(idx) == IX_OSC);
    assign wr_aux     = wr_acc && (32'(idx) == IX_AUX);

    sysctl_key_gate #(
        .OSC_INIT (OSC_RST),
        .AUX_INIT (AUX_RST)
    ) u_key_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_we  (wr_lock),
        .osc_we   (wr_osc),
        .aux_we   (wr_aux),
        .wdata    (bus_wdata),
        .lock_rd  (lock_rd),
        .osc_q    (osc_val),
        .aux_q    (aux_val),
        .unlocked (unlocked)
    );

    // bank 0: flags at 12/13, bank 1: non-volatile flags at 14/15
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam int unsigned SET_IX = IX_FLG + 2 * g;
        assign flg_set[g] = wr_acc && (32'(idx) == SET_IX);
        assign flg_clr[g] = wr_acc && (32'(idx) == SET_IX + 1);
        sysctl_flag_bank #(
            .W (DW)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_en (flg_set[g]),
            .clr_en (flg_clr[g]),
            .wdata  (bus_wdata),
            .val_q  (flag_val[g])
        );
    end

    sysctl_pd_rom #(
        .MEM_MB  (MEM_MB),
        .ENTRIES (PD_ENTRIES)
    ) u_pd_rom (
        .entry  (idx[PD_AW-1:0]),
        .byte_o (pd_byte)
    );

    // read decode
    always_comb begin
        known = 1'b1;
        rval  = '0;
        if (pd_window) begin
            rval = pd_upper ? '0 : {24'h0, pd_byte};
        end else begin
            case (32'(idx))
                IX_ID:    rval = ID_WORD;
                IX_PROC:  rval = '0;
                IX_OSC:   rval = osc_val;
                IX_CTRL:  rval = {29'h0, state_q.map_sel, 1'b0, state_q.led};
                IX_STAT:  rval = STAT_WORD;
                IX_LOCK:  rval = lock_rd;
                IX_AUX:   rval = aux_val;
                IX_SDRAM: rval = state_q.sdram;
                IX_INIT:  rval = state_q.init;
                IX_FLG:   rval = flag_val[0];
                IX_FLGC:  rval = '0;
                IX_NVF:   rval = flag_val[1];
                IX_NVFC:  rval = '0;
                default:  known = 1'b0;
            endcase
        end
    end

    // next-state
    always_comb begin
        state_d         = state_q;
        state_d.rst_req = 1'b0;
        state_d.err     = bus_sel && !known;
        if (rd_acc) state_d.rdata = rval;
        if (wr_acc) begin
            case (32'(idx))
                IX_SDRAM: state_d.sdram = bus_wdata;
                IX_INIT:  state_d.init  = bus_wdata;
                IX_CTRL: begin
                    state_d.led     = bus_wdata[0];
                    state_d.map_sel = bus_wdata[2];
                    state_d.rst_req = bus_wdata[3];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RESET_STATE;
        else        state_q <= state_d;
    end

    assign bus_rdata    = state_q.rdata;
    assign led_on       = state_q.led;
    assign remap_active = !state_q.map_sel;
    assign reset_req    = state_q.rst_req;
    assign bad_access   = state_q.err;

    // R9: a reset request follows a control write carrying bit 3
    p_rst_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(wr_acc && (32'(idx) == IX_CTRL) && bus_wdata[3]));
    // R11: an error pulse follows an access
    p_err_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |-> $past(bus_sel));
    // R10: output levels move only after a control write
    p_lvl_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(led_on) || !$stable(remap_active)) |->
            $past(wr_acc && (32'(idx) == IX_CTRL)));
    // R12: read data holds without a read
    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_acc) |-> $stable(bus_rdata));

endmodule

// File: tb/sysctl_regs_test.sv
`timescale 1ns/1ps
module sysctl_regs_test;

    localparam int unsigned ADDR_W = 9;
    localparam int unsigned MEM_MB = 128;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              remap_active, led_on, reset_req, bad_access;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          done = 1'b0;

    // model state
    logic [15:0] m_lock;
    logic [31:0] m_osc, m_aux, m_sdram, m_init, m_flg, m_nvf, m_rdata;
    logic        m_led, m_sel;

    always #4 clk = ~clk;

    sysctl_regs #(.ADDR_W(ADDR_W), .MEM_MB(MEM_MB)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .remap_active(remap_active), .led_on(led_on),
        .reset_req(reset_req), .bad_access(bad_access));

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pd_exp(int e);
        case (e)
            0: return 8'h80;  1: return 8'h08;  2: return 8'h04;
            3: return 8'h0B;  4: return 8'h09;  5: return 8'h01;
            6: return 8'h40;  31: return 8'd32; // 128 MB
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit known_ix(int ix);
        if (ix >= 64 && ix < 128) return 1'b1;
        return ix inside {0, 1, 2, 3, 4, 5, 7, 8, 9, 12, 13, 14, 15};
    endfunction

    function automatic logic [31:0] exp_rd(int ix);
        if (ix >= 96 && ix < 128) return 32'h0;
        if (ix >= 64 && ix < 96)  return {24'h0, pd_exp(ix - 64)};
        case (ix)
            0: return 32'h411A3001;
            4: return 32'h00100000;
            2: return m_osc;
            7: return m_aux;
            3: return {29'h0, m_sel, 1'b0, m_led};
            5: return (m_lock == 16'hA05F) ? 32'h0001A05F : {16'h0, m_lock};
            8: return m_sdram;
            9: return m_init;
            12: return m_flg;
            14: return m_nvf;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_wr(int ix, logic [31:0] d);
        case (ix)
            2: if (m_lock == 16'hA05F) m_osc = d;
            7: if (m_lock == 16'hA05F) m_aux = d;
            5: m_lock = d[15:0];
            8: m_sdram = d;
            9: m_init = d;
            3: begin m_led = d[0]; m_sel = d[2]; end
            12: m_flg = m_flg | d;
            13: m_flg = m_flg & ~d;
            14: m_nvf = m_nvf | d;
            15: m_nvf = m_nvf & ~d;
            default: ;
        endcase
    endtask

    // one access; called at a negedge, returns at a negedge with bus idle
    task automatic acc(bit we, int ix, logic [31:0] d, string req);
        bus_sel   = 1'b1;
        bus_we    = we;
        bus_addr  = ADDR_W'(ix << 2);
        bus_wdata = d;
        if (!we) m_rdata = exp_rd(ix);
        else     model_wr(ix, d);
        @(posedge clk);
        @(negedge clk);
        check({req, " rdata"}, bus_rdata, m_rdata);
        check("R11 bad_access", 32'(bad_access), 32'(!known_ix(ix)));
        check("R9 reset_req", 32'(reset_req), 32'(we && ix == 3 && d[3]));
        check("R10 led_on", 32'(led_on), 32'(m_led));
        check("R10 remap_active", 32'(remap_active), 32'(!m_sel));
        bus_sel = 1'b0;
        bus_we  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        m_lock = '0; m_osc = 32'h01000048; m_aux = 32'h0007FEFF;
        m_sdram = 32'h0001112E; m_init = 32'h00000112;
        m_flg = '0; m_nvf = '0; m_rdata = '0; m_led = 1'b0; m_sel = 1'b0;
        void'($urandom(32'd7321));

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 rdata", bus_rdata, 32'h0);
        check("R1 remap_active", 32'(remap_active), 32'h1);
        check("R1 led_on", 32'(led_on), 32'h0);
        check("R1 reset_req", 32'(reset_req), 32'h0);
        check("R1 bad_access", 32'(bad_access), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 remap after release", 32'(remap_active), 32'h1);

        // R2: constants; writes ignored
        acc(0, 0, '0, "R2");
        acc(1, 0, 32'hFFFF_FFFF, "R2");
        acc(0, 0, '0, "R2");
        acc(0, 1, '0, "R2");
        acc(0, 4, '0, "R2");

        // R7, R8: reset values and plain read/write
        acc(0, 8, '0, "R7");
        acc(0, 9, '0, "R8");
        acc(1, 8, 32'hDEAD_BEEF, "R8");
        acc(0, 8, '0, "R8");
        acc(1, 9, 32'h1234_5678, "R8");
        acc(0, 9, '0, "R8");

        // R4, R3: lock gating
        acc(0, 2, '0, "R4");
        acc(0, 7, '0, "R4");
        acc(1, 2, 32'hAAAA_5555, "R4");
        acc(0, 2, '0, "R4");
        acc(1, 5, 32'h1234_A05F, "R3");
        acc(0, 5, '0, "R3");
        acc(1, 2, 32'hAAAA_5555, "R4");
        acc(0, 2, '0, "R4");
        acc(1, 7, 32'h0BAD_F00D, "R4");
        acc(0, 7, '0, "R4");
        acc(1, 5, 32'hFFFF_A05E, "R3");
        acc(0, 5, '0, "R3");
        acc(1, 7, 32'h0, "R4");
        acc(0, 7, '0, "R4");

        // R5: flag set/clear
        acc(1, 12, 32'h0000_00F0, "R5");
        acc(1, 12, 32'h0000_0F00, "R5");
        acc(0, 12, '0, "R5");
        acc(1, 13, 32'h0000_0130, "R5");
        acc(0, 12, '0, "R5");
        acc(0, 13, '0, "R5");
        acc(1, 14, 32'h8000_0001, "R5");
        acc(1, 15, 32'h0000_0001, "R5");
        acc(0, 14, '0, "R5");
        acc(0, 12, '0, "R5");

        // R6: table window
        acc(0, 64, '0, "R6");
        acc(0, 66, '0, "R6");
        acc(0, 70, '0, "R6");
        acc(0, 95, '0, "R6");
        acc(0, 80, '0, "R6");
        acc(0, 96, '0, "R6");
        acc(0, 127, '0, "R6");

        // R9, R10: control
        acc(1, 3, 32'h0000_0008, "R9");
        @(posedge clk); @(negedge clk);
        check("R9 pulse ends", 32'(reset_req), 32'h0);
        acc(1, 3, 32'h0000_0005, "R10");
        acc(0, 3, '0, "R10");
        acc(1, 3, 32'h0000_0001, "R10");
        acc(1, 3, 32'h0000_0000, "R10");

        // R11: undecoded indices
        acc(0, 6, '0, "R11");
        acc(1, 10, 32'hFFFF_FFFF, "R11");
        @(posedge clk); @(negedge clk);
        check("R11 pulse ends", 32'(bad_access), 32'h0);
        acc(1, 33, 32'hFFFF_FFFF, "R11");
        acc(0, 9, '0, "R11");

        // R12 and everything: seeded random traffic
        for (int i = 0; i < 400; i++) begin
            int ix;
            bit we;
            logic [31:0] d;
            case ($urandom_range(0, 3))
                0: ix = $urandom_range(0, 15);
                1: ix = $urandom_range(64, 127);
                2: ix = $urandom_range(0, 127);
                default: ix = 5;
            endcase
            we = $urandom_range(0, 1) == 1;
            d  = $urandom;
            if (ix == 5 && $urandom_range(0, 1) == 1) d[15:0] = 16'hA05F;
            acc(we, ix, d, "R12");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule